// File: doc/BRIEF.md
# SPI EEPROM Page Writer

This block sits on the host side of a serial EEPROM whose array is written in 16-byte pages. A client starts it with a one-cycle pulse, a 10-bit start address and a byte count. The client then streams the bytes in over a valid/ready handshake. The block turns that request into a series of SPI mode-0 transactions. Each page gets a write-enable frame, then a write frame, then status polling until the device reports its internal write finished.

Transfers are cut at page boundaries, so no single write frame runs past the end of a 16-byte page. Chip select is raised only on a byte boundary. The line stays high for at least a set number of clocks between frames. When the last page's internal write has completed, the block raises a one-cycle done pulse. The SCK rate comes from a divider parameter.

Top module: `eeprom_page_writer`

## Requirements
- R1: Each page starts with a frame that carries only the byte 0x06, closed by chip select going high before the write frame begins.
- R2: A write frame sends 0x02, then the 16-bit address as high byte {6'b0, addr[9:8]} and low byte addr[7:0], then the data bytes, every byte MSB first on MOSI.
- R3: A write frame carries min(bytes remaining, 16 - addr[3:0]) data bytes, so it never crosses a 16-byte page; the address then advances by that amount and wraps from 0x3FF to 0x000.
- R4: Chip select rises only after a whole number of bytes has been clocked in a frame, with SCK low, i.e. directly after the final bit of the last byte.
- R5: After each write frame the block sends status frames {0x05, 0x00}; bit 0 of the second byte read on MISO (MSB first) is the busy flag, and polling repeats while it is 1; the next page's 0x06 frame follows only after a 0.
- R6: Mode 0 timing: SCK is low whenever chip select is high, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R7: Chip select stays high for at least CS_GAP clock cycles between any two frames.
- R8: donePulse is high for exactly one cycle, directly after the last status frame that reports not-busy, with busy already low; a request with byteCount = 0 gives a done pulse with no bus activity; reset leaves chip select high, SCK low, busy, dataReady and donePulse low.
- R9: A data byte is taken only in a cycle with dataValid and dataReady both high; exactly byteCount bytes are taken; while the stream stalls, SCK holds low and chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to begin a transfer, honoured when idle |
| startAddr | input | 10 | First array address of the transfer |
| byteCount | input | 11 | Number of bytes to write |
| dataIn | input | 8 | Next byte of the stream |
| dataValid | input | 1 | dataIn holds a byte |
| dataReady | output | 1 | Block accepts a byte this cycle |
| busy | output | 1 | A transfer is in progress |
| donePulse | output | 1 | One-cycle completion flag |
| csN | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
The assertions assume that startReq is pulsed only while busy is low. They also assume that CLK_DIV and CS_GAP are at least one. The properties on the shifter, such as MOSI holding while SCK is high and chip select rising only when no bit is in flight, need nothing of the inputs beyond that. The bench raises requests only after the previous done pulse. It drives MISO from a memory model that changes the line right after each rising SCK edge, and it feeds bytes both back to back and with regular stalls. The unaligned, wrapping and zero-length requests keep within those limits too.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  typedef enum logic [2:0] {
    TX_WREN, TX_WRITE, TX_RDSR, TX_ADRH, TX_ADRL, TX_DATA, TX_DUMMY
  } txSel_e;

  typedef struct packed {
    logic   initXfer;
    logic   frameInit;
    logic   takeData;
    logic   loadTx;
    txSel_e txSel;
    logic   csDrop;
    logic   csRaise;
  } ctrlStrobe_t;

endpackage

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 11,
  parameter int PAGE_W  = 4,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        dataIn,
  input  logic              miso,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  output logic              byteDone,
  output logic              frameEmpty,
  output logic              remEmpty,
  output logic              wipBit
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int FRAME_W    = PAGE_W + 1;
  localparam int DIV_W      = $clog2(CLK_DIV + 1);
  localparam int SUM_W      = FRAME_W + 1;

  logic [ADDR_W-1:0]  addr;
  logic [CNT_W-1:0]   remaining;
  logic [FRAME_W-1:0] frameLeft;
  logic [FRAME_W-1:0] spaceLeft;
  logic [FRAME_W-1:0] frameSize;
  logic [15:0]        wideAddr;
  logic [7:0]         txByte;
  logic [7:0]         shReg;
  logic [DIV_W-1:0]   divCnt;
  logic [2:0]         bitCnt;
  logic               active;
  logic               sckR;
  logic               lastRx;
  logic               csR;

  // Transfer bookkeeping: address, bytes left overall and in this frame
  assign wideAddr  = 16'(addr);
  assign spaceLeft = FRAME_W'(PAGE_BYTES) - FRAME_W'(addr[PAGE_W-1:0]);
  assign frameSize = (remaining < CNT_W'(spaceLeft)) ? FRAME_W'(remaining) : spaceLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addr      <= '0;
      remaining <= '0;
      frameLeft <= '0;
    end else if (strb.initXfer) begin
      addr      <= startAddr;
      remaining <= byteCount;
      frameLeft <= '0;
    end else if (strb.frameInit) begin
      frameLeft <= frameSize;
    end else if (strb.takeData) begin
      addr      <= addr + 1'b1;
      remaining <= remaining - 1'b1;
      frameLeft <= frameLeft - 1'b1;
    end
  end

  assign frameEmpty = (frameLeft == '0);
  assign remEmpty   = (remaining == '0);

  // Outgoing byte selection
  always_comb begin
    case (strb.txSel)
      TX_WREN:  txByte = OP_WREN;
      TX_WRITE: txByte = OP_WRITE;
      TX_RDSR:  txByte = OP_RDSR;
      TX_ADRH:  txByte = wideAddr[15:8];
      TX_ADRL:  txByte = wideAddr[7:0];
      TX_DATA:  txByte = dataIn;
      default:  txByte = 8'h00;
    endcase
  end

  // Bit engine: mode 0, CLK_DIV clocks per SCK half period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      sckR     <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      shReg    <= '0;
      lastRx   <= 1'b0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strb.loadTx) begin
        shReg  <= txByte;
        active <= 1'b1;
        sckR   <= 1'b0;
        divCnt <= '0;
        bitCnt <= '0;
      end else if (active) begin
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          divCnt <= '0;
          if (!sckR) begin
            sckR   <= 1'b1;
            lastRx <= miso;
          end else begin
            sckR <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              shReg  <= {shReg[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             csR <= 1'b1;
    else if (strb.csDrop)  csR <= 1'b0;
    else if (strb.csRaise) csR <= 1'b1;
  end

  assign csN    = csR;
  assign sck    = sckR;
  assign mosi   = shReg[7];
  assign wipBit = lastRx;

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  // R4
  cs_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> ($past(!active) && !sck));

  // R3
  frame_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameInit |=> ((SUM_W'(frameLeft) + SUM_W'(addr[PAGE_W-1:0])) <= SUM_W'(PAGE_BYTES)
                        && frameLeft != '0));

  // R9
  take_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeData |-> (remaining != '0 && frameLeft != '0));

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int CS_GAP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             dataValid,
  input  logic             byteDone,
  input  logic             frameEmpty,
  input  logic             remEmpty,
  input  logic             wipBit,
  output ctrlStrobe_t      strb,
  output logic             dataReady,
  output logic             busy,
  output logic             donePulse
);

  localparam int GAP_W = $clog2(CS_GAP + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_GAP, S_WREN, S_WOP, S_ADRH, S_ADRL, S_FETCH, S_DATA, S_ROP, S_RSTAT
  } state_e;

  typedef enum logic [1:0] { F_WREN, F_WRITE, F_RDSR } frame_e;

  state_e           state, stateNxt;
  frame_e           nextFrame, nextFrameNxt;
  logic [GAP_W-1:0] gapCnt;
  logic             doneSet;

  always_comb begin
    strb         = '0;
    strb.txSel   = TX_DUMMY;
    stateNxt     = state;
    nextFrameNxt = nextFrame;
    doneSet      = 1'b0;
    dataReady    = 1'b0;
    case (state)
      S_IDLE: if (startReq) begin
        strb.initXfer = 1'b1;
        if (byteCount == '0) begin
          doneSet = 1'b1;
        end else begin
          nextFrameNxt = F_WREN;
          stateNxt     = S_GAP;
        end
      end
      S_GAP: if (gapCnt >= GAP_W'(CS_GAP - 1)) begin
        strb.csDrop = 1'b1;
        strb.loadTx = 1'b1;
        case (nextFrame)
          F_WREN:  begin strb.txSel = TX_WREN; stateNxt = S_WREN; end
          F_WRITE: begin strb.txSel = TX_WRITE; strb.frameInit = 1'b1; stateNxt = S_WOP; end
          default: begin strb.txSel = TX_RDSR; stateNxt = S_ROP; end
        endcase
      end
      S_WREN: if (byteDone) begin
        strb.csRaise = 1'b1;
        nextFrameNxt = F_WRITE;
        stateNxt     = S_GAP;
      end
      S_WOP: if (byteDone) begin
        strb.loadTx = 1'b1;
        strb.txSel  = TX_ADRH;
        stateNxt    = S_ADRH;
      end
      S_ADRH: if (byteDone) begin
        strb.loadTx = 1'b1;
        strb.txSel  = TX_ADRL;
        stateNxt    = S_ADRL;
      end
      S_ADRL: if (byteDone) stateNxt = S_FETCH;
      S_FETCH: begin
        dataReady = 1'b1;
        if (dataValid) begin
          strb.loadTx   = 1'b1;
          strb.txSel    = TX_DATA;
          strb.takeData = 1'b1;
          stateNxt      = S_DATA;
        end
      end
      S_DATA: if (byteDone) begin
        if (frameEmpty) begin
          strb.csRaise = 1'b1;
          nextFrameNxt = F_RDSR;
          stateNxt     = S_GAP;
        end else begin
          stateNxt = S_FETCH;
        end
      end
      S_ROP: if (byteDone) begin
        strb.loadTx = 1'b1;
        strb.txSel  = TX_DUMMY;
        stateNxt    = S_RSTAT;
      end
      S_RSTAT: if (byteDone) begin
        strb.csRaise = 1'b1;
        if (wipBit) begin
          nextFrameNxt = F_RDSR;
          stateNxt     = S_GAP;
        end else if (remEmpty) begin
          doneSet  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          nextFrameNxt = F_WREN;
          stateNxt     = S_GAP;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      nextFrame <= F_WREN;
      gapCnt    <= '0;
      donePulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      nextFrame <= nextFrameNxt;
      donePulse <= doneSet;
      if (state != S_GAP || stateNxt != S_GAP) gapCnt <= '0;
      else if (gapCnt != '1)                   gapCnt <= gapCnt + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !dataReady);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import pgw_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 11,
  parameter int PAGE_W  = 4,
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        dataIn,
  input  logic              dataValid,
  output logic              dataReady,
  output logic              busy,
  output logic              donePulse,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);

  ctrlStrobe_t strb;
  logic        byteDone, frameEmpty, remEmpty, wipBit;

  pgw_ctrl #(.CNT_W(CNT_W), .CS_GAP(CS_GAP)) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .byteCount(byteCount),
    .dataValid(dataValid), .byteDone(byteDone), .frameEmpty(frameEmpty),
    .remEmpty(remEmpty), .wipBit(wipBit), .strb(strb),
    .dataReady(dataReady), .busy(busy), .donePulse(donePulse)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .CLK_DIV(CLK_DIV)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .byteCount(byteCount), .dataIn(dataIn), .miso(miso),
    .csN(csN), .sck(sck), .mosi(mosi), .byteDone(byteDone),
    .frameEmpty(frameEmpty), .remEmpty(remEmpty), .wipBit(wipBit)
  );

endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;

  localparam int CLK_DIV    = 2;
  localparam int CS_GAP     = 3;
  localparam int BUSY_POLLS = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [9:0] startAddr = '0;
  logic [10:0] byteCount = '0;
  logic [7:0] dataIn = '0;
  logic       dataValid = 1'b0;
  logic       dataReady, busy, donePulse, csN, sck, mosi, miso;

  always #5 clk = ~clk;

  eeprom_page_writer #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAddr(startAddr),
    .byteCount(byteCount), .dataIn(dataIn), .dataValid(dataValid),
    .dataReady(dataReady), .busy(busy), .donePulse(donePulse),
    .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] streamByte(input int base, input int idx);
    return 8'((base + idx * 7) & 255);
  endfunction

  // Scoreboard queues: frame lengths and flattened expected bytes
  int         expLens[$];
  logic [7:0] expBytes[$];
  int         frameCount = 0;

  // Memory model on the bus
  int         bitCnt = 0;
  logic [7:0] shIn = '0;
  logic [7:0] frameBuf[$];
  int         busyPolls = 0;
  logic       curWip = 1'b0;
  logic       isRdsr = 1'b0;
  bit         inFrame = 0;
  int         gapCnt = 1000;
  int         gapViol = 0;
  int         sckViol = 0;
  logic [7:0] statusByte;

  assign statusByte = {7'b0, curWip};
  assign miso = (!csN && isRdsr && bitCnt >= 8 && bitCnt < 16)
                ? statusByte[3'(15 - bitCnt)] : 1'b0;

  always @(negedge clk) begin
    if (csN) gapCnt++;
    else gapCnt = 0;
    if (csN && sck) sckViol++;
  end

  always @(negedge csN) if (rstN) begin
    if (gapCnt < CS_GAP) gapViol++;
    inFrame = 1;
    bitCnt = 0;
    isRdsr = 1'b0;
    frameBuf.delete();
    curWip = (busyPolls > 0);
  end

  always @(posedge sck) begin
    if (csN) sckViol++;
    else begin
      shIn = {shIn[6:0], mosi};
      bitCnt++;
      if (bitCnt % 8 == 0) frameBuf.push_back(shIn);
      if (bitCnt == 8) isRdsr = (shIn == 8'h05);
    end
  end

  // Monitor: compare each finished frame against the scoreboard
  always @(posedge csN) if (rstN && inFrame) begin
    int   len;
    bit   ok;
    logic [7:0] e;
    logic [7:0] first;
    string req;
    inFrame = 0;
    frameCount++;
    check(bitCnt % 8 == 0, "R4", "frame ended mid-byte, bit count", bitCnt, 0);
    if (expLens.size() == 0) begin
      check(0, "R8", "unexpected frame, first byte",
            frameBuf.size() > 0 ? int'(frameBuf[0]) : -1, 0);
    end else begin
      len = expLens.pop_front();
      ok = (frameBuf.size() == len);
      first = expBytes[0];
      for (int i = 0; i < len; i++) begin
        e = expBytes.pop_front();
        if (i < frameBuf.size() && frameBuf[i] !== e) ok = 0;
      end
      req = (first == 8'h06) ? "R1" : (first == 8'h02) ? "R2 R3" : "R5";
      check(ok, req, "frame content (len/first byte)",
            frameBuf.size() * 256 + (frameBuf.size() > 0 ? int'(frameBuf[0]) : 0),
            len * 256 + int'(first));
    end
    if (frameBuf.size() > 0 && frameBuf[0] == 8'h02) busyPolls = BUSY_POLLS;
    else if (frameBuf.size() > 0 && frameBuf[0] == 8'h05 && busyPolls > 0) busyPolls--;
  end

  // Byte stream source
  int  feedCount = 0, feedBase = 0, feedIdx = 0, feedCyc = 0;
  bit  feedGap = 0;
  bit  pendAccept = 0;

  always @(negedge clk) begin
    if (pendAccept) feedIdx++;
    feedCyc++;
    if (feedIdx < feedCount && !(feedGap && (feedCyc % 3 == 0))) begin
      dataValid = 1'b1;
      dataIn    = streamByte(feedBase, feedIdx);
    end else begin
      dataValid = 1'b0;
    end
    #1 pendAccept = dataValid && dataReady;
  end

  task automatic pushFrame(input logic [7:0] b[$]);
    expLens.push_back(b.size());
    foreach (b[i]) expBytes.push_back(b[i]);
  endtask

  task automatic runXfer(input int a, input int n, input int base, input bit gap);
    int rem = n, ad = a, idx = 0, len;
    logic [7:0] fr[$];
    int framesBefore;
    while (rem > 0) begin
      fr = '{8'h06};
      pushFrame(fr);
      len = 16 - (ad % 16);
      if (rem < len) len = rem;
      fr = '{8'h02, 8'(ad >> 8), 8'(ad & 255)};
      for (int i = 0; i < len; i++) fr.push_back(streamByte(base, idx + i));
      pushFrame(fr);
      for (int p = 0; p <= BUSY_POLLS; p++) begin
        fr = '{8'h05, 8'h00};
        pushFrame(fr);
      end
      idx += len;
      ad = (ad + len) % 1024;
      rem -= len;
    end
    framesBefore = frameCount;
    gapViol = 0;
    sckViol = 0;
    @(negedge clk);
    feedIdx = 0; feedCount = n; feedBase = base; feedGap = gap;
    startAddr = 10'(a); byteCount = 11'(n); startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    while (!donePulse) @(negedge clk);
    check(expLens.size() == 0, "R8", "frames still expected at done", expLens.size(), 0);
    check(busy == 1'b0, "R8", "busy with done", busy, 0);
    if (n == 0) check(frameCount == framesBefore, "R8", "frames for empty request",
                      frameCount - framesBefore, 0);
    @(negedge clk);
    check(donePulse == 1'b0, "R8", "done wider than one cycle", donePulse, 0);
    check(feedIdx == n, "R9", "bytes consumed", feedIdx, n);
    check(gapViol == 0, "R7", "short chip-select gaps", gapViol, 0);
    check(sckViol == 0, "R6", "SCK high with chip select high", sckViol, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state, R6 idle SCK
    check(csN == 1'b1, "R8", "reset csN", csN, 1);
    check(sck == 1'b0, "R6", "reset sck", sck, 0);
    check(busy == 1'b0 && dataReady == 1'b0 && donePulse == 1'b0, "R8",
          "reset busy/ready/done", {busy, dataReady, donePulse}, 0);
    runXfer(10'h005, 1, 3, 0);     // R2 single byte
    runXfer(10'h00C, 20, 40, 0);   // R3 split 4 + 16
    runXfer(10'h3FE, 5, 90, 1);    // R3 wrap to 0x000, R9 stalls
    runXfer(10'h000, 0, 0, 0);     // R8 empty request
    runXfer(10'h010, 16, 17, 0);   // R3 aligned full page
    runXfer(10'h105, 33, 200, 1);  // R1 R5 several pages with stalls
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule